// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog and interval timer. It has an 8-bit up-counter that advances on a prescaled tick and an 8-bit control/status register. Both registers sit on a 16-bit write bus. The upper byte of every write must carry a key that belongs to the target register. A write whose key does not match is dropped without any sign.

Software starts the timer by setting the enable bit, picks a divide ratio and picks one of two modes. In watchdog mode the software must keep reloading the counter. If the counter wraps from 0xFF to 0x00, the block sets an overflow flag. In watchdog mode it then holds a reset request high for a fixed number of cycles. In interval mode it gives a one-cycle interrupt instead.

Control/status register layout:

| Bit | Name | Meaning |
|-----|------|---------|
| 7 | enable | timer enable |
| 6 | mode | 1 selects watchdog mode, 0 selects interval mode |
| 5:4 | spare | stored as written |
| 3 | overflow flag | set by a counter wrap |
| 2:0 | divide code | selects the prescale ratio |

Top module: `keyed_wdt`

## Requirements
- R1: A write with `reg_sel`=0 and `wr_data[15:8]`=0x5A loads `wr_data[7:0]` into the counter at that clock edge.
- R2: A write with `reg_sel`=1 and `wr_data[15:8]`=0xA5 loads the control/status register at that clock edge. The bit layout is: bit 7 enable, bit 6 mode (1 = watchdog, 0 = interval), bits 5:4 spare (stored), bit 3 overflow flag, bits 2:0 divide code.
- R3: A write whose upper byte is not the key of the selected register changes neither register. This includes a write that carries the other register's key.
- R4: `rd_data` returns, without a clock, the 8-bit counter when `reg_sel`=0 and the control/status register when `reg_sel`=1.
- R5: After reset, the counter and the control/status register are 0x00, and `rst_req` and `irq` are low.
- R6: While enabled, the counter increments once every 32·2^code clock cycles, where code is the divide code (code 0 gives 32 cycles, code 7 gives 4096 cycles).
- R7: While the enable bit is 0, the counter and the prescaler hold their values.
- R8: A wrap from 0xFF to 0x00 sets flag bit 3. A keyed control write with bit 3 = 0 clears the flag, and one with bit 3 = 1 leaves it unchanged. A wrap in the same cycle as a clearing write wins, so the flag stays set.
- R9: In watchdog mode, a wrap drives `rst_req` high for exactly 16 cycles, starting at the cycle after the wrap edge.
- R10: In interval mode, a wrap drives `irq` high for exactly one cycle, starting at the cycle after the wrap edge. `rst_req` stays low.
- R11: A keyed control write that changes the divide code restarts the prescaler from zero. The next tick then comes one full new period after the write.
- R12: A keyed counter write in the same cycle as a tick takes priority. The written value is loaded without an increment, and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, asynchronous |
| reg_sel | input | 1 | 0 selects the counter, 1 selects the control/status register |
| wr_en | input | 1 | write strobe |
| wr_data | input | 16 | key byte in bits [15:8], value in bits [7:0] |
| rd_data | output | 8 | value of the selected register |
| rst_req | output | 1 | reset request raised after a wrap in watchdog mode |
| irq | output | 1 | interrupt pulse raised after a wrap in interval mode |

## Verification
The embedded assertions check on every cycle the following:
- a wrongly keyed control write leaves the control fields unchanged;
- a disabled prescaler holds still;
- each tick adds exactly one to the counter;
- a wrap always sets the flag;
- an interrupt never lasts two cycles;
- a reset request only starts after a watchdog-mode wrap.

Only the bench scenarios can show the following:
- the exact divide periods;
- the prescaler restart after a divide change;
- the 16-cycle width of the reset request;
- the flag-clear rules;
- the priority of a counter write over a tick.

These are checked against a cycle-accurate model under directed cases and under seeded random keyed and unkeyed writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DIV_W = 3;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic             en;
      logic             wdog;
      logic [1:0]       spare;
      logic             ovf;
      logic [DIV_W-1:0] div;
   } wdt_csr_t;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
   import wdt_pkg::*;
#(
   parameter logic [BYTE_W-1:0] CNT_KEY = 8'h5A,
   parameter logic [BYTE_W-1:0] CSR_KEY = 8'hA5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                wr_en,
   input  logic [2*BYTE_W-1:0] wr_data,
   input  logic                ovf_evt,
   output wdt_csr_t            csr,
   output logic                cnt_ld,
   output logic [BYTE_W-1:0]   cnt_ld_val,
   output logic                div_chg
);
   logic [BYTE_W-1:0] key_b;
   logic [BYTE_W-1:0] val_b;
   logic              csr_wr;
   wdt_csr_t          wr_csr;
   wdt_csr_t          csr_q;

   initial begin
      if (CNT_KEY == CSR_KEY) $fatal(1, "wdt_regif: keys must differ");
   end

   assign key_b      = wr_data[2*BYTE_W-1:BYTE_W];
   assign val_b      = wr_data[BYTE_W-1:0];
   assign wr_csr     = wdt_csr_t'(val_b);
   assign csr_wr     = wr_en && reg_sel && (key_b == CSR_KEY);
   assign cnt_ld     = wr_en && !reg_sel && (key_b == CNT_KEY);
   assign cnt_ld_val = val_b;
   assign div_chg    = csr_wr && (wr_csr.div != csr_q.div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q <= '0;
      end else if (csr_wr) begin
         csr_q     <= wr_csr;
         csr_q.ovf <= (csr_q.ovf & wr_csr.ovf) | ovf_evt;
      end else begin
         csr_q.ovf <= csr_q.ovf | ovf_evt;
      end
   end

   assign csr = csr_q;

   // R3
   bad_csr_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel && key_b != CSR_KEY) |=>
         (csr_q[7:4] == $past(csr_q[7:4]) && csr_q.div == $past(csr_q.div)));

   // R8
   ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> csr_q.ovf);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int BASE_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   localparam int PW = BASE_LOG2 + (1 << DIV_W) - 1;

   logic [PW-1:0] pcnt;
   logic [PW:0]   span;
   logic [PW-1:0] last;

   initial begin
      if (BASE_LOG2 < 1 || PW > 24) $fatal(1, "wdt_prescaler: bad BASE_LOG2");
   end

   always_comb begin
      span = (PW+1)'(1) << (BASE_LOG2 + int'(div));
      last = PW'(span - (PW+1)'(1));
   end

   assign tick = en && !restart && (pcnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pcnt <= '0;
      else if (restart)         pcnt <= '0;
      else if (en) begin
         if (pcnt == last)      pcnt <= '0;
         else                   pcnt <= pcnt + PW'(1);
      end
   end

   // R7
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ld,
   input  logic [BYTE_W-1:0] ld_val,
   output logic [BYTE_W-1:0] cnt,
   output logic              ovf_evt
);
   logic [BYTE_W-1:0] cnt_q;

   assign ovf_evt = tick && !ld && (cnt_q == {BYTE_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (ld)   cnt_q <= ld_val;
      else if (tick) cnt_q <= cnt_q + BYTE_W'(1);
   end

   assign cnt = cnt_q;

   // R6
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld) |=> (cnt_q == $past(cnt_q) + BYTE_W'(1)));
endmodule

// File: rtl/wdt_signal.sv
module wdt_signal #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_evt,
   input  logic wdog,
   output logic rst_req,
   output logic irq
);
   logic irq_q;

   initial begin
      if (HOLD < 1) $fatal(1, "wdt_signal: HOLD must be at least 1");
   end

   generate
      if (HOLD > 1) begin : g_stretch
         localparam int HW = $clog2(HOLD + 1);
         logic [HW-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 hold_q <= '0;
            else if (ovf_evt && wdog)   hold_q <= HW'(HOLD);
            else if (hold_q != '0)      hold_q <= hold_q - HW'(1);
         end
         assign rst_req = (hold_q != '0);
      end else begin : g_single
         logic rq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rq_q <= 1'b0;
            else        rq_q <= ovf_evt && wdog;
         end
         assign rst_req = rq_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= ovf_evt && !wdog;
   end
   assign irq = irq_q;

   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R9
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(ovf_evt && wdog));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
   parameter logic [7:0] CNT_KEY   = 8'h5A,
   parameter logic [7:0] CSR_KEY   = 8'hA5,
   parameter int         BASE_LOG2 = 5,
   parameter int         RST_HOLD  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_sel,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [7:0]  rd_data,
   output logic        rst_req,
   output logic        irq
);
   import wdt_pkg::*;

   wdt_csr_t          csr;
   logic              cnt_ld;
   logic [BYTE_W-1:0] cnt_ld_val;
   logic              div_chg;
   logic              tick;
   logic [BYTE_W-1:0] cnt;
   logic              ovf_evt;

   wdt_regif #(.CNT_KEY(CNT_KEY), .CSR_KEY(CSR_KEY)) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .ovf_evt(ovf_evt), .csr(csr),
      .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .div_chg(div_chg));

   wdt_prescaler #(.BASE_LOG2(BASE_LOG2)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(csr.en), .div(csr.div),
      .restart(div_chg), .tick(tick));

   wdt_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_ld),
      .ld_val(cnt_ld_val), .cnt(cnt), .ovf_evt(ovf_evt));

   wdt_signal #(.HOLD(RST_HOLD)) u_sig (
      .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .wdog(csr.wdog),
      .rst_req(rst_req), .irq(irq));

   assign rd_data = reg_sel ? BYTE_W'(csr) : cnt;

   // R12
   load_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt == $past(cnt_ld_val)));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_data;
   logic        rst_req, irq;

   int n_chk = 0, n_fail = 0;

   logic [7:0] m_cnt = '0, m_csr = '0;
   int         m_p = 0, m_hold = 0;
   bit         m_irq = 1'b0;

   keyed_wdt u_dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req), .irq(irq));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // R6 R11 R12 R8 R9 R10 expectations, one clock edge
   task automatic model_edge(input bit a, input bit w, input logic [15:0] d);
      bit csr_w, cnt_w, divchg, en, mode, tick, ovf;
      int last, np, nh;
      logic [7:0] nc, ns;
      en = m_csr[7]; mode = m_csr[6];
      last = (32 << m_csr[2:0]) - 1;
      csr_w = w && a && d[15:8] == 8'hA5;
      cnt_w = w && !a && d[15:8] == 8'h5A;
      divchg = csr_w && d[2:0] != m_csr[2:0];
      tick = en && !divchg && m_p == last;
      ovf = tick && !cnt_w && m_cnt == 8'hFF;
      np = divchg ? 0 : (en ? (m_p == last ? 0 : m_p + 1) : m_p);
      nc = cnt_w ? d[7:0] : (tick ? m_cnt + 8'd1 : m_cnt);
      if (csr_w) ns = {d[7:4], (m_csr[3] & d[3]) | ovf, d[2:0]};
      else       ns = {m_csr[7:4], m_csr[3] | ovf, m_csr[2:0]};
      nh = (ovf && mode) ? 16 : (m_hold > 0 ? m_hold - 1 : 0);
      m_irq = ovf && !mode;
      m_p = np; m_cnt = nc; m_csr = ns; m_hold = nh;
   endtask

   task automatic step(input bit a, input bit w, input logic [15:0] d);
      reg_sel = a; wr_en = w; wr_data = d;
      @(posedge clk);
      model_edge(a, w, d);
      @(negedge clk);
      wr_en = 1'b0;
      chk(rd_data == (a ? m_csr : m_cnt), "R4 read", rd_data, a ? m_csr : m_cnt);
      chk(rst_req == (m_hold != 0), "R9 rst_req", rst_req, m_hold != 0);
      chk(irq == m_irq, "R10 irq", irq, m_irq);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0);
   endtask

   task automatic peek(input bit a, output logic [7:0] v);
      reg_sel = a; #1; v = rd_data;
   endtask

   initial begin
      #(CLK_P * 190000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int seen, width;
      repeat (3) @(negedge clk);
      // R5 reset state
      peek(1'b0, v); chk(v == 8'h00, "R5 counter", v, 0);
      peek(1'b1, v); chk(v == 8'h00, "R5 csr", v, 0);
      chk(rst_req == 1'b0 && irq == 1'b0, "R5 outputs", {rst_req, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 keyed counter load
      step(1'b0, 1'b1, 16'h5A37);
      peek(1'b0, v); chk(v == 8'h37, "R1 load", v, 8'h37);

      // R3 wrong keys
      step(1'b0, 1'b1, 16'h1299);
      step(1'b0, 1'b1, 16'hA599);
      step(1'b1, 1'b1, 16'h5A80);
      step(1'b1, 1'b1, 16'h0080);
      peek(1'b0, v); chk(v == 8'h37, "R3 counter kept", v, 8'h37);
      peek(1'b1, v); chk(v == 8'h00, "R3 csr kept", v, 0);

      // R2 keyed control load, interval mode, code 0
      step(1'b1, 1'b1, 16'hA5B0);
      peek(1'b1, v); chk(v == 8'hB0, "R2 load", v, 8'hB0);

      // R6 period of 32
      idle(31);
      peek(1'b0, v); chk(v == 8'h37, "R6 before tick", v, 8'h37);
      idle(1);
      peek(1'b0, v); chk(v == 8'h38, "R6 tick", v, 8'h38);

      // R7 disabled holds
      step(1'b1, 1'b1, 16'hA500);
      idle(100);
      peek(1'b0, v); chk(v == 8'h38, "R7 held", v, 8'h38);

      // R11 divide change restarts
      step(1'b1, 1'b1, 16'hA580);
      idle(10);
      step(1'b1, 1'b1, 16'hA581);
      idle(63);
      peek(1'b0, v); chk(v == 8'h38, "R11 before new tick", v, 8'h38);
      idle(1);
      peek(1'b0, v); chk(v == 8'h39, "R11 new tick", v, 8'h39);

      // R10 and R8: interval overflow
      step(1'b1, 1'b1, 16'hA580);
      step(1'b0, 1'b1, 16'h5AFF);
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
         idle(1);
         if (irq) seen = 1;
      end
      chk(seen == 1, "R10 irq seen", seen, 1);
      chk(rst_req == 1'b0, "R10 no reset", rst_req, 0);
      peek(1'b1, v); chk(v[3] == 1'b1, "R8 flag set", v[3], 1);
      peek(1'b0, v); chk(v == 8'h00, "R8 wrapped", v, 0);
      idle(1);
      chk(irq == 1'b0, "R10 one cycle", irq, 0);
      step(1'b1, 1'b1, 16'hA588);
      peek(1'b1, v); chk(v[3] == 1'b1, "R8 write one keeps", v[3], 1);
      step(1'b1, 1'b1, 16'hA580);
      peek(1'b1, v); chk(v[3] == 1'b0, "R8 write zero clears", v[3], 0);

      // R9 watchdog overflow, 16-cycle request
      step(1'b1, 1'b1, 16'hA5C0);
      step(1'b0, 1'b1, 16'h5AFF);
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
         idle(1);
         if (rst_req) seen = 1;
      end
      chk(seen == 1, "R9 request seen", seen, 1);
      width = 1;
      while (width < 40) begin
         idle(1);
         if (!rst_req) break;
         width++;
      end
      chk(width == 16, "R9 width", width, 16);

      // R12 load in tick cycle
      step(1'b1, 1'b1, 16'hA501);
      step(1'b1, 1'b1, 16'hA580);
      idle(31);
      step(1'b0, 1'b1, 16'h5A10);
      peek(1'b0, v); chk(v == 8'h10, "R12 load wins", v, 8'h10);
      idle(32);
      peek(1'b0, v); chk(v == 8'h11, "R12 next tick", v, 8'h11);

      // seeded random mix of keyed and unkeyed writes
      void'($urandom(32'd1234));
      for (int i = 0; i < 30000; i++) begin
         int r;
         logic [7:0] key, val;
         r = int'($urandom % 64);
         if (r == 0) begin
            key = ($urandom % 4 == 0) ? 8'($urandom) : 8'hA5;
            val = {($urandom % 4 != 0) ? 1'b1 : 1'b0, 4'($urandom), 3'($urandom % 3)};
            step(1'b1, 1'b1, {key, val});
         end else if (r == 1) begin
            key = ($urandom % 4 == 0) ? 8'($urandom) : 8'h5A;
            val = 8'hF0 | 8'($urandom % 16);
            step(1'b0, 1'b1, {key, val});
         end else begin
            step(1'($urandom), 1'b0, 16'($urandom));
         end
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule